// File: doc/BRIEF.md
# Parallel ADC Acquisition Sequencer

This block drives a successive-approximation converter that has a parallel result bus, an active-low chip select, a read/convert line and a busy flag. A conversion starts when a one-cycle start request arrives or when a free-running rate timer expires. The controller first lowers read/convert. One setup interval later it lowers chip select, which forms the convert command. It then watches busy fall and rise again before it opens the bus for a read. The captured 12-bit two's complement word is sign-extended and appears on a one-cycle valid/data output.

Every timing rule is counted in system clock cycles, and each has its own parameter. The rules are:

- the setup time of read/convert before chip select falls;
- the width of the convert command;
- the minimum spacing between convert commands;
- the bus access time;
- the bus relinquish time;
- the busy timeout.

A request that comes in while a conversion is in flight, or before the spacing has elapsed, is kept as one pending request and is served as soon as the rules allow. A converter that never drops busy, or never raises it again, sets a sticky error flag. The sequencer then returns to idle without performing a read.

Top module: `adc_acq_ctrl`

## Requirements
- R1: After reset, cs_n_o and rc_o are 1, bus_free_o is 1, vld_o is 0 and err_o is 0. Reset is synchronous and active high, and it clears err_o.
- R2: Before each convert command, rc_o is 0 with cs_n_o at 1 for at least SETUP_CYC cycles. The convert condition (cs_n_o = 0 and rc_o = 0) then lasts exactly PULSE_CYC cycles.
- R3: Two successive convert commands begin at least SPACING_CYC cycles apart.
- R4: After a convert command, the controller first sees busy_i go low and only then high. The read condition (cs_n_o = 0, rc_o = 1) is never driven while busy_i is low.
- R5: The read condition is held for ACCESS_CYC cycles. adc_bus_i is sampled in its last cycle, and vld_o is high for exactly one cycle on the next cycle.
- R6: data_o carries the 12-bit word in bits 11:0, and bit 11 is copied into every upper bit (0x800 gives 0xF800, 0x7FF gives 0x07FF).
- R7: bus_free_o is 0 from the start of the setup phase. It returns to 1 no sooner than RELEASE_CYC cycles after the read condition ends, and it is never 1 while busy_i is low after a convert command.
- R8: If busy_i does not fall within TIMEOUT_CYC cycles of the convert command, or does not rise within TIMEOUT_CYC cycles of falling, err_o goes to 1 and stays 1 until reset. The controller returns to idle (cs_n_o = 1, bus_free_o = 1) and vld_o stays 0.
- R9: Start requests that arrive during a conversion collapse into one pending request. That request is served once the spacing allows, so it yields exactly one further conversion.
- R10: A nonzero rate_period_i of P starts a conversion every P cycles, subject to spacing. A value of 0 stops the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle conversion request |
| rate_period_i | input | TMR_W | Rate timer period in cycles, 0 disables |
| busy_i | input | 1 | Converter busy flag, low while converting |
| adc_bus_i | input | ADC_W | Converter parallel result bus |
| cs_n_o | output | 1 | Converter chip select, active low |
| rc_o | output | 1 | Read (1) / convert (0) select |
| bus_free_o | output | 1 | Shared bus may be driven by others |
| vld_o | output | 1 | One-cycle strobe for data_o |
| data_o | output | OUT_W | Sign-extended captured word |
| err_o | output | 1 | Sticky busy-timeout flag |

## Verification
The converter model in the bench can be told to keep busy high or to hold it low indefinitely. The stuck-high case catches a controller that takes a stale high busy as completion: such a design would read and raise vld_o instead of flagging err_o. Requests issued while busy is low check that extra starts merge into one conversion and that the second convert command is not issued before the spacing has elapsed. Words with bit 11 set check for a controller that zero-fills the output. Monitors at the pins measure the setup time, the pulse width and the bus release gap, and they count any read attempted while busy is low.

// File: rtl/adc_acq_pkg.sv
package adc_acq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_PULSE,
        ST_WFALL,
        ST_WRISE,
        ST_READ,
        ST_REL
    } seq_state_e;

    typedef struct packed {
        logic cs_n;
        logic rc;
    } ctl_lines_t;

    // Control line levels for each phase of the sequence
    function automatic ctl_lines_t ctl_of(seq_state_e s);
        ctl_lines_t c;
        case (s)
            ST_SETUP: c = '{cs_n: 1'b1, rc: 1'b0};
            ST_PULSE: c = '{cs_n: 1'b0, rc: 1'b0};
            ST_READ:  c = '{cs_n: 1'b0, rc: 1'b1};
            default:  c = '{cs_n: 1'b1, rc: 1'b1};
        endcase
        return c;
    endfunction

    function automatic int max_of(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/adc_pace.sv
module adc_pace
    import adc_acq_pkg::*;
#(
    parameter int SPACING_CYC = 63,
    parameter int TMR_W       = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [TMR_W-1:0] period_i,
    input  logic             idle_i,
    input  logic             conv_start_i,
    output logic             go_o
);
    localparam int SW = $clog2(SPACING_CYC + 1);

    logic [SW-1:0]    sp_cnt;
    logic [TMR_W-1:0] tmr;
    logic             pend_q;
    logic             sp_ok;
    logic             tick;

    assign sp_ok = (sp_cnt == SW'(SPACING_CYC - 1));
    assign tick  = (period_i != '0) && (tmr == period_i - 1'b1);
    assign go_o  = idle_i && sp_ok && (start_i || tick || pend_q);

    // Spacing counter restarts on every convert command and saturates
    always_ff @(posedge clk) begin
        if (rst)               sp_cnt <= SW'(SPACING_CYC - 1);
        else if (conv_start_i) sp_cnt <= '0;
        else if (!sp_ok)       sp_cnt <= sp_cnt + 1'b1;
    end

    // Rate timer
    always_ff @(posedge clk) begin
        if (rst || period_i == '0)         tmr <= '0;
        else if (tmr >= period_i - 1'b1)   tmr <= '0;
        else                               tmr <= tmr + 1'b1;
    end

    // Requests that cannot be served at once merge into one pending flag
    always_ff @(posedge clk) begin
        if (rst)                    pend_q <= 1'b0;
        else if (go_o)              pend_q <= 1'b0;
        else if (start_i || tick)   pend_q <= 1'b1;
    end

    AST_GO_NEEDS_SPACING: assert property (@(posedge clk) disable iff (rst)
        conv_start_i |=> !go_o); // R3

endmodule

// File: rtl/adc_phase_fsm.sv
module adc_phase_fsm
    import adc_acq_pkg::*;
#(
    parameter int SETUP_CYC   = 1,
    parameter int PULSE_CYC   = 2,
    parameter int ACCESS_CYC  = 4,
    parameter int RELEASE_CYC = 5,
    parameter int TIMEOUT_CYC = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic go_i,
    input  logic busy_i,
    output logic cs_n_o,
    output logic rc_o,
    output logic conv_start_o,
    output logic capture_o,
    output logic idle_o,
    output logic err_o
);
    localparam int MAXC = max_of(max_of(SETUP_CYC, PULSE_CYC),
                                 max_of(max_of(ACCESS_CYC, RELEASE_CYC), TIMEOUT_CYC));
    localparam int CW = $clog2(MAXC + 1);

    seq_state_e  st;
    logic [CW-1:0] cnt;
    logic        err_q;
    ctl_lines_t  ctl;

    assign ctl          = ctl_of(st);
    assign cs_n_o       = ctl.cs_n;
    assign rc_o         = ctl.rc;
    assign idle_o       = (st == ST_IDLE);
    assign conv_start_o = (st == ST_SETUP) && (cnt == CW'(SETUP_CYC - 1));
    assign capture_o    = (st == ST_READ) && (cnt == CW'(ACCESS_CYC - 1));
    assign err_o        = err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            cnt   <= '0;
            err_q <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (go_i) begin st <= ST_SETUP; cnt <= '0; end
                ST_SETUP:
                    if (cnt == CW'(SETUP_CYC - 1)) begin st <= ST_PULSE; cnt <= '0; end
                    else cnt <= cnt + 1'b1;
                ST_PULSE:
                    if (cnt == CW'(PULSE_CYC - 1)) begin st <= ST_WFALL; cnt <= '0; end
                    else cnt <= cnt + 1'b1;
                ST_WFALL:
                    if (!busy_i) begin st <= ST_WRISE; cnt <= '0; end
                    else if (cnt == CW'(TIMEOUT_CYC - 1)) begin st <= ST_IDLE; err_q <= 1'b1; end
                    else cnt <= cnt + 1'b1;
                ST_WRISE:
                    if (busy_i) begin st <= ST_READ; cnt <= '0; end
                    else if (cnt == CW'(TIMEOUT_CYC - 1)) begin st <= ST_IDLE; err_q <= 1'b1; end
                    else cnt <= cnt + 1'b1;
                ST_READ:
                    if (cnt == CW'(ACCESS_CYC - 1)) begin st <= ST_REL; cnt <= '0; end
                    else cnt <= cnt + 1'b1;
                ST_REL:
                    if (cnt == CW'(RELEASE_CYC - 1)) begin st <= ST_IDLE; cnt <= '0; end
                    else cnt <= cnt + 1'b1;
                default: st <= ST_IDLE;
            endcase
        end
    end

    AST_SETUP_BEFORE_CS: assert property (@(posedge clk) disable iff (rst)
        (!cs_n_o && !rc_o && $past(cs_n_o)) |-> $past(!rc_o)); // R2

    AST_READ_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
        (!cs_n_o && rc_o) |-> busy_i); // R4

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o); // R8

    AST_TIMEOUT_IDLE: assert property (@(posedge clk) disable iff (rst)
        $rose(err_o) |-> (idle_o && cs_n_o && rc_o)); // R8

endmodule

// File: rtl/adc_acq_ctrl.sv
module adc_acq_ctrl
    import adc_acq_pkg::*;
#(
    parameter int ADC_W       = 12,
    parameter int OUT_W       = 16,
    parameter int TMR_W       = 16,
    parameter int SETUP_CYC   = 1,
    parameter int PULSE_CYC   = 2,
    parameter int SPACING_CYC = 63,
    parameter int ACCESS_CYC  = 4,
    parameter int RELEASE_CYC = 5,
    parameter int TIMEOUT_CYC = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [TMR_W-1:0] rate_period_i,
    input  logic             busy_i,
    input  logic [ADC_W-1:0] adc_bus_i,
    output logic             cs_n_o,
    output logic             rc_o,
    output logic             bus_free_o,
    output logic             vld_o,
    output logic [OUT_W-1:0] data_o,
    output logic             err_o
);
    localparam int EXT = OUT_W - ADC_W;
    localparam int GW  = $clog2(SPACING_CYC + 1);

    logic go, idle, conv_start, capture;
    logic vld_q;
    logic [OUT_W-1:0] data_q;

    adc_pace #(
        .SPACING_CYC(SPACING_CYC),
        .TMR_W      (TMR_W)
    ) u_pace (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .period_i    (rate_period_i),
        .idle_i      (idle),
        .conv_start_i(conv_start),
        .go_o        (go)
    );

    adc_phase_fsm #(
        .SETUP_CYC  (SETUP_CYC),
        .PULSE_CYC  (PULSE_CYC),
        .ACCESS_CYC (ACCESS_CYC),
        .RELEASE_CYC(RELEASE_CYC),
        .TIMEOUT_CYC(TIMEOUT_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .go_i        (go),
        .busy_i      (busy_i),
        .cs_n_o      (cs_n_o),
        .rc_o        (rc_o),
        .conv_start_o(conv_start),
        .capture_o   (capture),
        .idle_o      (idle),
        .err_o       (err_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= 1'b0;
            data_q <= '0;
        end else begin
            vld_q <= capture;
            if (capture) data_q <= {{EXT{adc_bus_i[ADC_W-1]}}, adc_bus_i};
        end
    end

    assign vld_o      = vld_q;
    assign data_o     = data_q;
    assign bus_free_o = idle;

    // Checker state: cycles since the previous convert command began
    logic          conv_now, conv_prev;
    logic [GW-1:0] gap;
    assign conv_now = !cs_n_o && !rc_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            conv_prev <= 1'b0;
            gap       <= GW'(SPACING_CYC);
        end else begin
            conv_prev <= conv_now;
            if (conv_now && !conv_prev)      gap <= GW'(1);
            else if (gap != GW'(SPACING_CYC)) gap <= gap + 1'b1;
        end
    end

    AST_CONV_SPACING: assert property (@(posedge clk) disable iff (rst)
        (conv_now && !conv_prev) |-> (gap >= GW'(SPACING_CYC))); // R3

    AST_VLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        vld_o |=> !vld_o); // R5

    AST_CAPTURE_WORD: assert property (@(posedge clk) disable iff (rst)
        vld_o |-> (data_o[ADC_W-1:0] == $past(adc_bus_i))); // R5

    AST_SIGN_FILL: assert property (@(posedge clk) disable iff (rst)
        vld_o |-> (data_o[OUT_W-1:ADC_W] == {EXT{$past(adc_bus_i[ADC_W-1])}})); // R6

    AST_BUS_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!cs_n_o && !rc_o) |-> !bus_free_o); // R7

endmodule

// File: tb/tb_adc_acq_ctrl.sv
module tb_adc_acq_ctrl;
    localparam int ADC_W = 12, OUT_W = 16, TMR_W = 16;
    localparam int SETUP_CYC = 1, PULSE_CYC = 2, SPACING_CYC = 63;
    localparam int ACCESS_CYC = 4, RELEASE_CYC = 5, TIMEOUT_CYC = 128;
    localparam int BUSY_DLY = 3, CONV_LEN = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [TMR_W-1:0] period = '0;
    logic busy;
    logic [ADC_W-1:0] abus;
    logic cs_n, rc, bus_free, vld, err;
    logic [OUT_W-1:0] data;

    int n_checks = 0, n_fail = 0, cycle = 0;

    always #10 clk = ~clk;

    adc_acq_ctrl #(
        .ADC_W(ADC_W), .OUT_W(OUT_W), .TMR_W(TMR_W),
        .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC), .SPACING_CYC(SPACING_CYC),
        .ACCESS_CYC(ACCESS_CYC), .RELEASE_CYC(RELEASE_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
    ) dut (
        .clk(clk), .rst(rst), .start_i(start), .rate_period_i(period),
        .busy_i(busy), .adc_bus_i(abus), .cs_n_o(cs_n), .rc_o(rc),
        .bus_free_o(bus_free), .vld_o(vld), .data_o(data), .err_o(err)
    );

    // Converter model
    logic nofall = 1'b0, norise = 1'b0;
    logic [ADC_W-1:0] next_word = '0, latch_w = '0;
    logic m_act;
    int m_cnt;

    always @(posedge clk) begin
        if (rst) begin
            busy <= 1'b1; m_act <= 1'b0; m_cnt <= 0;
        end else if (!m_act) begin
            if (!cs_n && !rc && busy) begin m_act <= 1'b1; m_cnt <= 0; end
        end else begin
            m_cnt <= m_cnt + 1;
            if (m_cnt == BUSY_DLY && !nofall) busy <= 1'b0;
            if (m_cnt == BUSY_DLY + CONV_LEN && !nofall && !norise) begin
                busy <= 1'b1; m_act <= 1'b0; latch_w <= next_word;
            end
        end
    end
    assign abus = (!cs_n && rc && busy) ? latch_w : '0;

    // Pin monitors, sampled away from the active edge
    int n_conv, n_vld, min_gap, last_fall, setup_run, last_setup;
    int pulse_run, last_pulse, bad_read, bad_free, rel_start, rel_gap;
    logic prev_conv, prev_read, prev_free;

    task automatic clr_mon();
        n_conv = 0; n_vld = 0; min_gap = 1000000; last_fall = -1;
        last_setup = 0; last_pulse = 0; bad_read = 0; bad_free = 0; rel_gap = -1;
    endtask

    initial begin
        clr_mon(); setup_run = 0; pulse_run = 0; rel_start = 0;
        prev_conv = 0; prev_read = 0; prev_free = 1;
    end

    always @(negedge clk) begin
        cycle++;
        if (!rst) begin
            if (!cs_n && !rc) begin
                if (!prev_conv) begin
                    n_conv++;
                    if (last_fall >= 0 && cycle - last_fall < min_gap) min_gap = cycle - last_fall;
                    last_fall = cycle; last_setup = setup_run; setup_run = 0; pulse_run = 0;
                end
                pulse_run++;
            end else begin
                if (prev_conv) last_pulse = pulse_run;
                if (cs_n && !rc) setup_run++; else setup_run = 0;
            end
            if (!cs_n && rc && !busy) bad_read++;
            if (bus_free && !busy) bad_free++;
            if (prev_read && !(!cs_n && rc)) rel_start = cycle;
            if (bus_free && !prev_free) rel_gap = cycle - rel_start;
            if (vld) n_vld++;
            prev_conv = !cs_n && !rc; prev_read = !cs_n && rc; prev_free = bus_free;
        end
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; start = 1'b0; period = '0;
        wait_cyc(3); rst = 1'b0; wait_cyc(1); clr_mon();
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check(cs_n === 1'b1, "R1 cs_n", int'(cs_n), 1);
        check(rc === 1'b1, "R1 rc", int'(rc), 1);
        check(bus_free === 1'b1, "R1 bus_free", int'(bus_free), 1);
        check(vld === 1'b0, "R1 vld", int'(vld), 0);
        check(err === 1'b0, "R1 err", int'(err), 0);
    endtask

    task automatic t_word(input logic [ADC_W-1:0] w, input logic [OUT_W-1:0] exp);
        int seen = 0;
        wait_cyc(SPACING_CYC + 5);
        next_word = w;
        pulse_start();
        for (int i = 0; i < 200 && seen == 0; i++) begin
            @(negedge clk);
            if (vld) begin
                seen = 1;
                check(data === exp, "R6 sign-extended word", int'(data), int'(exp));
            end
        end
        check(seen == 1, "R5 vld strobe after read", seen, 1);
    endtask

    task automatic t_timing();
        wait_cyc(SPACING_CYC + 5); clr_mon();
        next_word = 12'h0A5; pulse_start(); wait_cyc(150);
        check(last_setup >= SETUP_CYC, "R2 setup before cs fall", last_setup, SETUP_CYC);
        check(last_pulse == PULSE_CYC, "R2 convert pulse width", last_pulse, PULSE_CYC);
        check(bad_read == 0, "R4 read while busy low", bad_read, 0);
        check(rel_gap >= RELEASE_CYC, "R7 bus release gap", rel_gap, RELEASE_CYC);
        check(bad_free == 0, "R7 bus free during conversion", bad_free, 0);
        check(n_vld == 1, "R5 one strobe per conversion", n_vld, 1);
    endtask

    task automatic t_pending();
        wait_cyc(SPACING_CYC + 5); clr_mon();
        pulse_start();
        wait (busy == 1'b0);
        pulse_start(); pulse_start(); pulse_start();
        wait_cyc(400);
        check(n_conv == 2, "R9 merged pending requests", n_conv, 2);
        check(n_vld == 2, "R9 pending request served", n_vld, 2);
        check(min_gap >= SPACING_CYC, "R3 convert spacing", min_gap, SPACING_CYC);
    endtask

    task automatic t_timer();
        wait_cyc(SPACING_CYC + 5); clr_mon();
        period = 16'd100; wait_cyc(1000);
        check(n_conv >= 9 && n_conv <= 11, "R10 timer rate", n_conv, 10);
        period = '0; wait_cyc(150); clr_mon(); wait_cyc(300);
        check(n_conv == 0, "R10 timer disabled", n_conv, 0);
    endtask

    task automatic t_nofall();
        do_reset(); nofall = 1'b1;
        pulse_start(); wait_cyc(TIMEOUT_CYC + 50);
        check(err === 1'b1, "R8 error on busy stuck high", int'(err), 1);
        check(n_vld == 0, "R8 no read on stale busy", n_vld, 0);
        check(cs_n === 1'b1 && bus_free === 1'b1, "R8 idle after timeout",
              int'({cs_n, bus_free}), 3);
        wait_cyc(20);
        check(err === 1'b1, "R8 error sticky", int'(err), 1);
        nofall = 1'b0; do_reset();
        check(err === 1'b0, "R1 reset clears error", int'(err), 0);
    endtask

    task automatic t_norise();
        do_reset(); norise = 1'b1;
        pulse_start(); wait_cyc(TIMEOUT_CYC + 60);
        check(err === 1'b1, "R8 error on busy stuck low", int'(err), 1);
        check(n_vld == 0, "R8 no strobe without completion", n_vld, 0);
        check(bus_free === 1'b1, "R8 idle after rise timeout", int'(bus_free), 1);
        norise = 1'b0; do_reset();
    endtask

    initial begin
        t_reset();
        t_word(12'h123, 16'h0123);
        t_word(12'h800, 16'hF800);
        t_word(12'hFFF, 16'hFFFF);
        t_word(12'h7FF, 16'h07FF);
        t_timing();
        t_pending();
        t_timer();
        t_nofall();
        t_norise();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        wait (cycle > 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycle);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule